// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank Controller with Combined Interrupt

The block controls one bank of sixteen general-purpose pins through a small 16-bit register bus. Software reads the synchronized pin levels and drives an output data word and a per-pin output-enable word. It also sets up per-pin interrupt detection: an enable, a type (edge or level) and a polarity for each pin. All enabled pending interrupts of the bank merge into one interrupt line. A chip that needs 32 pins places two instances. A global signal number then splits into a bank index (number shifted right by four) and a bit index (low four bits).

Every control word has a write-1-to-set offset and a write-1-to-clear offset. Software can therefore change single bits without a read-modify-write. Output data has an extra masked-write window: the word offset inside the window is itself the bit mask, so one write updates exactly the selected output bits. Because the output data is held while a pin is not driven, software can preset a level before it turns the driver on. The pin then does not glitch.

Register selection is a decoded enumeration (`reg_sel_e`) with one value for each offset. Each pin's detector is in one of four named detect modes: LVL_LOW (type 0, polarity 0), LVL_HIGH (type 0, polarity 1), EDGE_FALL (type 1, polarity 0) and EDGE_RISE (type 1, polarity 1). The mode changes only when software writes the type or polarity words.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, output data, output enable, interrupt enable, type and polarity are all zero. `pin_oe` is zero and `irq_o` is low.
- R2: A read of offset 0 returns `pin_in` after a two-flop synchronizer. A change made between clock edges is visible after the second rising edge and not after the first.
- R3: A write to offset 1 loads the output data word, which appears on `pin_out`. A read of offset 1 returns it.
- R4: A write to offset 2 ORs the write data into output enable. A write to offset 3 clears the bits set in the write data. Other bits are unchanged, and a read of either offset returns the enable word.
- R5: Interrupt enable (set 4, clear 5), interrupt type (set 6, clear 7) and polarity (set 8, clear 9) follow the same write-1 rule. A read of either offset of a pair returns that word.
- R6: An address with bit 16 set is a masked-write window. Address bits 15:0 are the mask, and output data bits in the mask take the write data while all other bits keep their values.
- R7: With type 1, polarity 1 selects a rising edge and polarity 0 a falling edge. A matching edge sets the pending bit after the third rising edge from the pin change. The bit stays set until it is cleared, and the opposite edge does not set it.
- R8: With type 0, the pending bit is set on every cycle in which the synchronized pin equals the polarity bit. A clear write made while the condition holds leaves the bit set.
- R9: A read of offset 10 returns the pending word. A write to offset 10 clears the pending bits set in the write data.
- R10: `irq_o` is high exactly when some pending bit has its enable bit set. A pending pin whose enable is clear does not raise it.
- R11: Output data is held while output enable is clear. Setting enable bits does not change `pin_out`.
- R12: Offsets 11 to 15 (bit 16 clear) read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 17 | Word address: bit 16 selects the masked window, low bits select a register or carry the mask |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads, asynchronous |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Per-pin output enable |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The masked window is driven with a sequence of masks:
- a byte mask,
- a single nibble,
- an empty mask,
- a full mask,
- a sparse mask,
- a mask with only the two end bits.

Together these separate "only masked bits change" from whole-word writes and from ignored writes. The interrupt detector is tried with rising and falling pin transitions under each edge polarity, which shows whether polarity selects the edge. Steady high and low levels in level mode show a pending bit that re-asserts after a clear, as distinct from an edge bit that stays cleared. The set/clear pairs are tried with overlapping masks, which separates OR and AND-NOT updates from plain loads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register offsets (bit 16 of the address clear)
    typedef enum logic [3:0] {
        SEL_DIN      = 4'd0,
        SEL_DOUT     = 4'd1,
        SEL_OE_SET   = 4'd2,
        SEL_OE_CLR   = 4'd3,
        SEL_IE_SET   = 4'd4,
        SEL_IE_CLR   = 4'd5,
        SEL_TYPE_SET = 4'd6,
        SEL_TYPE_CLR = 4'd7,
        SEL_POL_SET  = 4'd8,
        SEL_POL_CLR  = 4'd9,
        SEL_STAT     = 4'd10,
        SEL_NONE     = 4'd15
    } reg_sel_e;

    // Per-pin detect mode, encoded as {type, polarity}
    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_RISE = 2'b11
    } det_mode_e;

    localparam int unsigned SEL_W = 4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             win_wr,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wmask,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] oe_q,
    output logic [NPINS-1:0] ie_q,
    output logic [NPINS-1:0] itype_q,
    output logic [NPINS-1:0] ipol_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            oe_q    <= '0;
            ie_q    <= '0;
            itype_q <= '0;
            ipol_q  <= '0;
        end else if (wr_en) begin
            if (win_wr) begin
                dout_q <= (dout_q & ~wmask) | (wdata & wmask);
            end else begin
                unique case (sel)
                    SEL_DOUT:     dout_q  <= wdata;
                    SEL_OE_SET:   oe_q    <= oe_q | wdata;
                    SEL_OE_CLR:   oe_q    <= oe_q & ~wdata;
                    SEL_IE_SET:   ie_q    <= ie_q | wdata;
                    SEL_IE_CLR:   ie_q    <= ie_q & ~wdata;
                    SEL_TYPE_SET: itype_q <= itype_q | wdata;
                    SEL_TYPE_CLR: itype_q <= itype_q & ~wdata;
                    SEL_POL_SET:  ipol_q  <= ipol_q | wdata;
                    SEL_POL_CLR:  ipol_q  <= ipol_q & ~wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] itype_i,
    input  logic [NPINS-1:0] ipol_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] pend_o
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;

    function automatic logic det_hit(det_mode_e m, logic cur, logic prv);
        logic h;
        unique case (m)
            LVL_LOW:   h = !cur;
            LVL_HIGH:  h = cur;
            EDGE_FALL: h = prv && !cur;
            EDGE_RISE: h = cur && !prv;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

    always_comb begin
        for (int i = 0; i < int'(NPINS); i++) begin
            hit[i] = det_hit(det_mode_e'({itype_i[i], ipol_i[i]}), lvl_i[i], prev_q[i]);
        end
    end

    // A new hit wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_o <= '0;
        end else begin
            prev_q <= lvl_i;
            pend_o <= (pend_o & ~clr_i) | hit;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = NPINS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_o
);
    localparam int unsigned WIN_BIT = ADDR_W - 1;

    logic             wr_stb;
    logic             win_wr;
    reg_sel_e         sel;
    logic [NPINS-1:0] din_sync;
    logic [NPINS-1:0] ie_q;
    logic [NPINS-1:0] itype_q;
    logic [NPINS-1:0] ipol_q;
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] stat_clr;

    assign wr_stb = bus_valid && bus_write;
    assign win_wr = bus_addr[WIN_BIT];

    // Offset decode: only exact offsets 0..10 below the window select a register
    always_comb begin
        sel = SEL_NONE;
        if (!bus_addr[WIN_BIT] && (bus_addr[WIN_BIT-1:SEL_W] == '0)
            && (bus_addr[SEL_W-1:0] <= 4'd10)) begin
            sel = reg_sel_e'(bus_addr[SEL_W-1:0]);
        end
    end

    assign stat_clr = (wr_stb && !win_wr && sel == SEL_STAT) ? bus_wdata : '0;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (din_sync)
    );

    gpio_ctrl_regs #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_stb),
        .win_wr (win_wr),
        .sel    (sel),
        .wmask  (bus_addr[NPINS-1:0]),
        .wdata  (bus_wdata),
        .dout_q (pin_out),
        .oe_q   (pin_oe),
        .ie_q   (ie_q),
        .itype_q(itype_q),
        .ipol_q (ipol_q)
    );

    gpio_irq_unit #(.NPINS(NPINS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (din_sync),
        .itype_i(itype_q),
        .ipol_i (ipol_q),
        .clr_i  (stat_clr),
        .pend_o (pend_q)
    );

    always_comb begin
        unique case (sel)
            SEL_DIN:                   bus_rdata = din_sync;
            SEL_DOUT:                  bus_rdata = pin_out;
            SEL_OE_SET,   SEL_OE_CLR:   bus_rdata = pin_oe;
            SEL_IE_SET,   SEL_IE_CLR:   bus_rdata = ie_q;
            SEL_TYPE_SET, SEL_TYPE_CLR: bus_rdata = itype_q;
            SEL_POL_SET,  SEL_POL_CLR:  bus_rdata = ipol_q;
            SEL_STAT:                  bus_rdata = pend_q;
            default:                   bus_rdata = '0;
        endcase
    end

    assign irq_o = |(pend_q & ie_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = NPINS + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  ie_q,
    input logic [NPINS-1:0]  pend_q,
    input logic              irq_o
);
    logic             wr;
    logic             win;
    logic [NPINS-1:0] lo;
    logic [NPINS-1:0] clr_now;

    assign wr      = bus_valid && bus_write;
    assign win     = bus_addr[ADDR_W-1];
    assign lo      = bus_addr[NPINS-1:0];
    assign clr_now = (wr && !win && lo == NPINS'(10)) ? bus_wdata : '0;

    a_r4_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !win && lo == NPINS'(2)) |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)));

    a_r4_oe_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !win && lo == NPINS'(3)) |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

    a_r6_window_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && win) |=> ((pin_out ^ $past(pin_out)) & ~$past(lo)) == '0);

    a_r6_window_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && win) |=> ((pin_out ^ $past(bus_wdata)) & $past(lo)) == '0);

    a_r11_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !win && lo == NPINS'(2)) |=> $stable(pin_out));

    a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq_o);

    a_r7_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(pend_q & ~clr_now) & ~pend_q) == '0);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .ie_q     (ie_q),
    .pend_q   (pend_q),
    .irq_o    (irq_o)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
    localparam int N = 16;
    localparam int AW = N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    // {mask, write data, expected output data}; starts from output data 0
    localparam logic [47:0] WIN_TAB [6] = '{
        {16'h00FF, 16'hA5A5, 16'h00A5},
        {16'hF000, 16'h1234, 16'h10A5},
        {16'h0000, 16'hFFFF, 16'h10A5},
        {16'hFFFF, 16'h5A5A, 16'h5A5A},
        {16'h0F0F, 16'h0000, 16'h5050},
        {16'h8001, 16'hFFFF, 16'hD051}
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [N-1:0] v, input int edges);
        @(negedge clk);
        pin_in = v;
        repeat (edges) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] d;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(AW'(1), d);  check("R1 dout", d, 16'h0000);
        rd(AW'(2), d);  check("R1 oe", d, 16'h0000);
        rd(AW'(4), d);  check("R1 ie", d, 16'h0000);
        rd(AW'(6), d);  check("R1 type", d, 16'h0000);
        rd(AW'(8), d);  check("R1 pol", d, 16'h0000);
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);

        // R2 two-flop synchronizer on data-in
        bus_addr = AW'(0);
        @(negedge clk) pin_in = 16'h1234;
        @(posedge clk); @(negedge clk); #2;
        check("R2 one edge", bus_rdata, 16'h0000);
        @(posedge clk); @(negedge clk); #2;
        check("R2 two edges", bus_rdata, 16'h1234);

        // R3 direct output data
        wr(AW'(1), 16'hBEEF);
        rd(AW'(1), d); check("R3 dout read", d, 16'hBEEF);
        check("R3 pin_out", pin_out, 16'hBEEF);
        check("R11 held while disabled", pin_oe, 16'h0000);

        // R4 output enable set/clear
        wr(AW'(2), 16'h00F0);
        wr(AW'(2), 16'h0F00);
        rd(AW'(2), d); check("R4 oe set", d, 16'h0FF0);
        wr(AW'(3), 16'h0030);
        rd(AW'(3), d); check("R4 oe clr", d, 16'h0FC0);
        check("R4 pin_oe", pin_oe, 16'h0FC0);

        // R11 enabling drives preset level unchanged
        wr(AW'(2), 16'hFFFF);
        check("R11 pin_out after enable", pin_out, 16'hBEEF);
        check("R11 pin_oe", pin_oe, 16'hFFFF);

        // R5 interrupt control words
        wr(AW'(4), 16'h8001);
        rd(AW'(4), d); check("R5 ie set", d, 16'h8001);
        rd(AW'(5), d); check("R5 ie via clr addr", d, 16'h8001);
        wr(AW'(5), 16'h0001);
        rd(AW'(4), d); check("R5 ie clr", d, 16'h8000);
        wr(AW'(6), 16'h00FF);
        wr(AW'(7), 16'h000F);
        rd(AW'(7), d); check("R5 type", d, 16'h00F0);
        wr(AW'(8), 16'h3C00);
        rd(AW'(9), d); check("R5 pol set", d, 16'h3C00);
        wr(AW'(9), 16'h3C00);
        rd(AW'(8), d); check("R5 pol clr", d, 16'h0000);
        wr(AW'(5), 16'hFFFF);
        wr(AW'(7), 16'hFFFF);

        // R6 masked-write window, table walk
        wr(AW'(1), 16'h0000);
        for (int i = 0; i < 6; i++) begin
            wr({1'b1, WIN_TAB[i][47:32]}, WIN_TAB[i][31:16]);
            check("R6 window", pin_out, WIN_TAB[i][15:0]);
        end
        rd(AW'(1), d); check("R6 window readback", d, 16'hD051);

        // R12 unmapped offsets
        rd(AW'(12), d); check("R12 read zero", d, 16'h0000);
        wr(AW'(11), 16'hFFFF);
        wr(AW'(15), 16'h0000);
        rd(AW'(1), d); check("R12 dout kept", d, 16'hD051);
        rd(AW'(4), d); check("R12 ie kept", d, 16'h0000);
        rd(AW'(2), d); check("R12 oe kept", d, 16'hFFFF);

        // R7 edge interrupts on pin 0
        set_pins(16'h0000, 3);
        wr(AW'(6), 16'h0001);
        wr(AW'(8), 16'h0001);
        wr(AW'(4), 16'h0001);
        wr(AW'(10), 16'hFFFF);
        rd(AW'(10), d); check("R9 cleared", d & 16'h0001, 16'h0000);
        check("R10 idle irq", {15'd0, irq_o}, 16'h0000);
        set_pins(16'h0001, 3);
        rd(AW'(10), d); check("R7 rising pending", d & 16'h0001, 16'h0001);
        check("R10 irq raised", {15'd0, irq_o}, 16'h0001);
        repeat (5) @(posedge clk);
        rd(AW'(10), d); check("R7 held", d & 16'h0001, 16'h0001);
        wr(AW'(10), 16'h0001);
        rd(AW'(10), d); check("R9 clear edge", d & 16'h0001, 16'h0000);
        check("R10 irq drops", {15'd0, irq_o}, 16'h0000);
        set_pins(16'h0000, 4);
        rd(AW'(10), d); check("R7 falling ignored", d & 16'h0001, 16'h0000);
        wr(AW'(9), 16'h0001);
        set_pins(16'h0001, 4);
        rd(AW'(10), d); check("R7 rising ignored", d & 16'h0001, 16'h0000);
        set_pins(16'h0000, 4);
        rd(AW'(10), d); check("R7 falling pending", d & 16'h0001, 16'h0001);
        wr(AW'(10), 16'h0001);
        wr(AW'(5), 16'h0001);

        // R8 level interrupt on pin 1 (type 0, high)
        wr(AW'(8), 16'h0002);
        wr(AW'(10), 16'h0002);
        rd(AW'(10), d); check("R8 idle level", d & 16'h0002, 16'h0000);
        set_pins(16'h0002, 3);
        rd(AW'(10), d); check("R8 level pending", d & 16'h0002, 16'h0002);
        check("R10 disabled pending", {15'd0, irq_o}, 16'h0000);
        wr(AW'(10), 16'h0002);
        rd(AW'(10), d); check("R8 reasserts after clear", d & 16'h0002, 16'h0002);
        wr(AW'(4), 16'h0002);
        check("R10 enabled level", {15'd0, irq_o}, 16'h0001);
        set_pins(16'h0000, 3);
        wr(AW'(10), 16'h0002);
        rd(AW'(10), d); check("R9 level cleared", d & 16'h0002, 16'h0000);
        check("R10 level irq drops", {15'd0, irq_o}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule